// File: doc/BRIEF.md
# SPI Bitstream Loader for a Configurable Target

This block brings up a target FPGA that takes its configuration as an SPI slave. After a start pulse it holds the target in reset, waits for the target to clear its configuration memory, and checks that the target's done line is low. It then sends one byte of idle clocks, streams the whole bitstream with chip select held low, sends trailing clocks, and checks that done has gone high. A last burst of clocks lets the target switch on its user pins. At any checkpoint the load can end with an error code instead.

The bitstream arrives as a byte stream with valid, ready and a last flag. While a byte is being shifted out, ready is held low. The next byte is taken in the final cycle of the current one, so the SPI clock runs without a break across byte boundaries. Every timed wait is set in nanoseconds or microseconds and turned into system clock cycles from a clock-frequency parameter. The SPI clock half-period is a divider parameter.

Top module: `fpga_cfg_loader`

## Requirements
- R1: One clock after a start pulse is accepted, the target reset output and the chip select output both go low together. Reset stays low for at least RST_NS of system time. No SPI clock edge occurs while reset is low.
- R2: After reset is released, no SPI clock edge occurs for at least CLEAR_US of system time.
- R3: If the synchronised done input is high after the clear wait, the load stops with error code 3 (status). No SPI clock is issued.
- R4: Before the image, with chip select high, exactly 8 SPI clocks are sent with MOSI low.
- R5: The image is sent with chip select low. It is every stream byte in order, MSB first, and all rising SPI clock edges are exactly 2*SCK_HALF system cycles apart with no gap between bytes.
- R6: After the last image byte, chip select goes high and 8*TRAIL_BYTES clocks are sent with MOSI low (104 by default).
- R7: If done is low after the trailing clocks, the load stops with error code 3 and sends no further clocks.
- R8: If done is high there, 8*WAKE_BYTES more zero clocks follow (104 by default), then ok goes high with error code 0.
- R9: If done rises before the last image byte has been accepted, the load stops with error code 2 (pin negotiation).
- R10: If the stream has no byte ready when an image byte ends and the last byte has not yet been sent, the load stops with error code 1 (SPI transfer).
- R11: Start is only honoured while idle. Busy stays high from the start until ok or an error code is latched, and never together with a result. Reset is never reasserted during a run. After reset, all control outputs are inactive: reset high, select high, clock and MOSI low, busy and ok low, error 0.
- R12: SPI mode 0: the clock idles low, and MOSI changes only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| bs_valid_i | input | 1 | Bitstream byte valid |
| bs_data_i | input | 8 | Bitstream byte |
| bs_last_i | input | 1 | Marks the final bitstream byte |
| bs_ready_o | output | 1 | Loader accepts a byte this cycle |
| cfg_done_i | input | 1 | Target done status (asynchronous) |
| cfg_rst_n_o | output | 1 | Target reset, active low |
| cfg_cs_n_o | output | 1 | Target chip select, active low |
| cfg_sck_o | output | 1 | SPI clock |
| cfg_mosi_o | output | 1 | SPI data to the target |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 2 | Last error: 0 none, 1 transfer, 2 pin, 3 status |

## Verification
On every cycle, the assertions check the mode-0 data timing, that select is low whenever reset is low, that no clock runs during reset, that ready is only offered with select low, that busy and a result are never seen together, and that reset is never reasserted during a run. Counts and contents can only be shown by the bench's scenarios: the 8 pre-image clocks, the image bytes and their spacing, the 104 trailing and 104 wake clocks, the length of the reset and clear waits, and which error code each failure path produces.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_CLEAR,
    ST_CHK_LOW,
    ST_PRE,
    ST_STREAM,
    ST_TRAIL,
    ST_CHK_HIGH,
    ST_WAKE
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_XFER   = 2'd1,
    ERR_PIN    = 2'd2,
    ERR_STATUS = 2'd3
  } err_code_t;

  function automatic longint ceil_div(input longint num, input longint den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       accept_o,
  output logic       last_o,
  output logic       sck_o,
  output logic       mosi_o
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(HALF_DIV - 1);

  logic          active_q;
  logic          phase_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic [7:0]    sh_q;
  logic          half_end;

  always_comb begin
    half_end = (div_q == DIV_END);
    last_o   = active_q & phase_q & half_end & (bit_q == 3'd7);
    accept_o = ~active_q | last_o;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      div_q    <= '0;
      sh_q     <= '0;
    end else if (load_i && accept_o) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      div_q    <= '0;
      sh_q     <= byte_i;
    end else if (active_q) begin
      if (half_end) begin
        div_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            sh_q     <= '0;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sck_o  = active_q & phase_q;
  assign mosi_o = sh_q[7];

  AST_MOSI_LOW_CHANGE: assert property (@(posedge clk) disable iff (rst) // R12
    !$stable(mosi_o) |-> !sck_o)
    else $error("mosi changed while sck high");

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int RST_CYC     = 20,
  parameter int CLEAR_CYC   = 120000,
  parameter int TRAIL_BYTES = 13,
  parameter int WAKE_BYTES  = 13,
  parameter int TW          = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          done_i,
  input  logic          s_valid_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  input  logic          sh_accept_i,
  input  logic          sh_last_i,
  output logic          sh_load_o,
  output logic          sh_flush_o,
  output logic [7:0]    sh_byte_o,
  output logic          creset_n_o,
  output logic          cs_n_o,
  output logic          busy_o,
  output logic          ok_o,
  output logic [1:0]    err_o
);

  localparam int MAXB = (TRAIL_BYTES > WAKE_BYTES) ? TRAIL_BYTES : WAKE_BYTES;
  localparam int CW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] TRAIL_N = CW'(TRAIL_BYTES);
  localparam logic [CW-1:0] WAKE_N  = CW'(WAKE_BYTES);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          got_last_q, got_last_d;
  logic [1:0]    dsync_q;
  logic          done_s;
  logic          fin_ok;
  err_code_t     fin_err;

  assign done_s = dsync_q[1];

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    got_last_d = got_last_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_flush_o = 1'b0;
    sh_byte_o  = 8'h00;
    s_ready_o  = 1'b0;
    fin_ok     = 1'b0;
    fin_err    = ERR_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_RST_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(RST_CYC);
        end
      end
      ST_RST_HOLD: begin
        if (tmr_zero_i) begin
          state_d    = ST_CLEAR;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(CLEAR_CYC);
        end
      end
      ST_CLEAR: begin
        if (tmr_zero_i) state_d = ST_CHK_LOW;
      end
      ST_CHK_LOW: begin
        if (done_s) begin
          fin_err = ERR_STATUS;
        end else begin
          state_d = ST_PRE;
          cnt_d   = '0;
        end
      end
      ST_PRE: begin
        if (sh_accept_i && cnt_q == '0) begin
          sh_load_o = 1'b1;
          cnt_d     = CW'(1);
        end else if (sh_last_i) begin
          state_d    = ST_STREAM;
          got_last_d = 1'b0;
        end
      end
      ST_STREAM: begin
        if (done_s && !got_last_q) begin
          fin_err = ERR_PIN;
        end else begin
          s_ready_o = sh_accept_i & ~got_last_q;
          sh_byte_o = s_data_i;
          if (s_valid_i && s_ready_o) begin
            sh_load_o = 1'b1;
            if (s_last_i) got_last_d = 1'b1;
          end
          if (sh_last_i && got_last_q) begin
            state_d = ST_TRAIL;
            cnt_d   = '0;
          end else if (sh_last_i && !s_valid_i) begin
            fin_err = ERR_XFER;
          end
        end
      end
      ST_TRAIL: begin
        if (sh_accept_i && cnt_q < TRAIL_N) begin
          sh_load_o = 1'b1;
          cnt_d     = cnt_q + CW'(1);
        end else if (sh_last_i) begin
          state_d = ST_CHK_HIGH;
        end
      end
      ST_CHK_HIGH: begin
        if (done_s) begin
          state_d = ST_WAKE;
          cnt_d   = '0;
        end else begin
          fin_err = ERR_STATUS;
        end
      end
      ST_WAKE: begin
        if (sh_accept_i && cnt_q < WAKE_N) begin
          sh_load_o = 1'b1;
          cnt_d     = cnt_q + CW'(1);
        end else if (sh_last_i) begin
          state_d = ST_IDLE;
          fin_ok  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin_err != ERR_NONE) begin
      state_d    = ST_IDLE;
      sh_flush_o = 1'b1;
      sh_load_o  = 1'b0;
      s_ready_o  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      got_last_q <= 1'b0;
      dsync_q    <= '0;
      creset_n_o <= 1'b1;
      cs_n_o     <= 1'b1;
      busy_o     <= 1'b0;
      ok_o       <= 1'b0;
      err_o      <= ERR_NONE;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      got_last_q <= got_last_d;
      dsync_q    <= {dsync_q[0], done_i};
      creset_n_o <= (state_d != ST_RST_HOLD);
      cs_n_o     <= !(state_d inside {ST_RST_HOLD, ST_CLEAR, ST_CHK_LOW, ST_STREAM});
      busy_o     <= (state_d != ST_IDLE);
      if (state_q == ST_IDLE && start_i) begin
        ok_o  <= 1'b0;
        err_o <= ERR_NONE;
      end else begin
        if (fin_ok) ok_o <= 1'b1;
        if (fin_err != ERR_NONE) err_o <= fin_err;
      end
    end
  end

  AST_CS_WITH_RESET: assert property (@(posedge clk) disable iff (rst) // R1
    !creset_n_o |-> !cs_n_o)
    else $error("select high while target held in reset");

  AST_READY_CS_LOW: assert property (@(posedge clk) disable iff (rst) // R5
    s_ready_o |-> (!cs_n_o && creset_n_o))
    else $error("ready offered outside the image phase");

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst) // R11
    busy_o |-> (!ok_o && err_o == ERR_NONE))
    else $error("result visible while busy");

  AST_NO_RERESET: assert property (@(posedge clk) disable iff (rst) // R11
    (busy_o && creset_n_o) |=> creset_n_o)
    else $error("reset reasserted during a run");

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int RST_NS      = 200,
  parameter int CLEAR_US    = 1200,
  parameter int SCK_HALF    = 2,
  parameter int TRAIL_BYTES = 13,
  parameter int WAKE_BYTES  = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       bs_valid_i,
  input  logic [7:0] bs_data_i,
  input  logic       bs_last_i,
  output logic       bs_ready_o,
  input  logic       cfg_done_i,
  output logic       cfg_rst_n_o,
  output logic       cfg_cs_n_o,
  output logic       cfg_sck_o,
  output logic       cfg_mosi_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic [1:0] err_o
);

  localparam int RST_CYC   = int'(ceil_div(longint'(CLK_HZ) * RST_NS, 64'd1_000_000_000));
  localparam int CLEAR_CYC = int'(ceil_div(longint'(CLK_HZ) * CLEAR_US, 64'd1_000_000));
  localparam int MAX_CYC   = (RST_CYC > CLEAR_CYC) ? RST_CYC : CLEAR_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sh_load, sh_flush, sh_accept, sh_last;
  logic [7:0]    sh_byte;

  cfgld_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cfgld_shifter #(.HALF_DIV(SCK_HALF)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .flush_i  (sh_flush),
    .load_i   (sh_load),
    .byte_i   (sh_byte),
    .accept_o (sh_accept),
    .last_o   (sh_last),
    .sck_o    (cfg_sck_o),
    .mosi_o   (cfg_mosi_o)
  );

  cfgld_seq #(
    .RST_CYC     (RST_CYC),
    .CLEAR_CYC   (CLEAR_CYC),
    .TRAIL_BYTES (TRAIL_BYTES),
    .WAKE_BYTES  (WAKE_BYTES),
    .TW          (TW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .done_i      (cfg_done_i),
    .s_valid_i   (bs_valid_i),
    .s_data_i    (bs_data_i),
    .s_last_i    (bs_last_i),
    .s_ready_o   (bs_ready_o),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sh_accept_i (sh_accept),
    .sh_last_i   (sh_last),
    .sh_load_o   (sh_load),
    .sh_flush_o  (sh_flush),
    .sh_byte_o   (sh_byte),
    .creset_n_o  (cfg_rst_n_o),
    .cs_n_o      (cfg_cs_n_o),
    .busy_o      (busy_o),
    .ok_o        (ok_o),
    .err_o       (err_o)
  );

  AST_NO_SCK_IN_RESET: assert property (@(posedge clk) disable iff (rst) // R1
    !cfg_rst_n_o |-> !cfg_sck_o)
    else $error("SPI clock active while target in reset");

endmodule

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;

  localparam int HALF    = 2;
  localparam int NTR     = 13;
  localparam int NWK     = 13;
  localparam int RST_CYC = 20;
  localparam int CLR_CYC = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       bs_valid_i = 1'b0;
  logic [7:0] bs_data_i = 8'h00;
  logic       bs_last_i = 1'b0;
  logic       bs_ready_o;
  logic       cfg_done_i = 1'b0;
  logic       cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o, cfg_mosi_o;
  logic       busy_o, ok_o;
  logic [1:0] err_o;

  always #5 clk = ~clk;

  fpga_cfg_loader #(
    .CLK_HZ(100_000_000), .RST_NS(200), .CLEAR_US(1),
    .SCK_HALF(HALF), .TRAIL_BYTES(NTR), .WAKE_BYTES(NWK)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .bs_valid_i(bs_valid_i), .bs_data_i(bs_data_i), .bs_last_i(bs_last_i),
    .bs_ready_o(bs_ready_o), .cfg_done_i(cfg_done_i),
    .cfg_rst_n_o(cfg_rst_n_o), .cfg_cs_n_o(cfg_cs_n_o),
    .cfg_sck_o(cfg_sck_o), .cfg_mosi_o(cfg_mosi_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // environment state
  int         cyc = 0;
  bit         run_on = 1'b0;
  int         n_img, idx, stall_at, done_mode;
  bit         hs;
  logic [7:0] img [16];
  logic [7:0] cap [16];
  logic [7:0] shreg;
  int         pre_cnt, pre_ones, img_bits, post_cnt, post_ones;
  int         rst_low, rst_falls, gap_max, last_rise, rst_rise_cyc, first_rise_cyc;
  bit         seen_img, cs_hi_in_rst;
  logic       prev_sck, prev_rst;

  always @(negedge clk) begin
    cyc++;
    if (run_on) begin
      if (hs) idx++;
      bs_valid_i = (idx < n_img) && (idx != stall_at);
      bs_data_i  = (idx < n_img) ? img[idx] : 8'h00;
      bs_last_i  = (idx == n_img - 1);
      hs = bs_valid_i && bs_ready_o;

      if (!cfg_rst_n_o) begin
        rst_low++;
        if (cfg_cs_n_o) cs_hi_in_rst = 1'b1;
      end
      if (prev_rst && !cfg_rst_n_o) rst_falls++;
      if (!prev_rst && cfg_rst_n_o) rst_rise_cyc = cyc;
      if (cfg_sck_o && !prev_sck) begin
        if (first_rise_cyc < 0) first_rise_cyc = cyc;
        if (!cfg_cs_n_o) begin
          if (seen_img && (cyc - last_rise) > gap_max) gap_max = cyc - last_rise;
          last_rise = cyc;
          seen_img  = 1'b1;
          shreg     = {shreg[6:0], cfg_mosi_o};
          img_bits++;
          if (img_bits % 8 == 0 && img_bits / 8 <= 16) cap[img_bits/8 - 1] = shreg;
        end else if (!seen_img) begin
          pre_cnt++;
          if (cfg_mosi_o) pre_ones++;
        end else begin
          post_cnt++;
          if (cfg_mosi_o) post_ones++;
        end
      end
      prev_sck = cfg_sck_o;
      prev_rst = cfg_rst_n_o;

      case (done_mode)
        0: cfg_done_i = seen_img && cfg_cs_n_o && (img_bits == 8 * n_img);
        1: cfg_done_i = 1'b1;
        2: cfg_done_i = 1'b0;
        default: cfg_done_i = (img_bits >= 8);
      endcase
    end
  end

  task automatic finish_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run(input int n, input int mode, input int stall, input bit restart,
                     input int seed);
    int t;
    n_img = n; idx = 0; stall_at = stall; done_mode = mode; hs = 1'b0;
    for (int k = 0; k < 16; k++) begin
      img[k] = 8'((k * 73 + seed * 29 + 8'h5A) & 8'hFF);
      cap[k] = 8'h00;
    end
    shreg = 8'h00; pre_cnt = 0; pre_ones = 0; img_bits = 0; post_cnt = 0; post_ones = 0;
    rst_low = 0; rst_falls = 0; gap_max = 0; last_rise = 0;
    rst_rise_cyc = -1; first_rise_cyc = -1; seen_img = 1'b0; cs_hi_in_rst = 1'b0;
    prev_sck = 1'b0; prev_rst = 1'b1; cfg_done_i = (mode == 1);
    run_on = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R11", "busy after start", int'(busy_o), 1);
    if (restart) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    t = 0;
    while (!(ok_o || err_o != 2'd0) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) begin
      chk(1'b0, "R11", "watchdog expired", t, 20000);
      finish_all();
    end
    chk(busy_o == 1'b0, "R11", "busy low with result", int'(busy_o), 0);
    repeat (8) @(negedge clk);
    run_on = 1'b0;
    bs_valid_i = 1'b0;
    cfg_done_i = 1'b0;
  endtask

  task automatic check_good(input int n);
    chk(ok_o == 1'b1, "R8", "ok", int'(ok_o), 1);
    chk(err_o == 2'd0, "R8", "err code", int'(err_o), 0);
    chk(rst_low >= RST_CYC, "R1", "reset low cycles", rst_low, RST_CYC);
    chk(cs_hi_in_rst == 1'b0, "R1", "select high during reset", int'(cs_hi_in_rst), 0);
    chk(first_rise_cyc - rst_rise_cyc >= CLR_CYC, "R2", "clear wait cycles",
        first_rise_cyc - rst_rise_cyc, CLR_CYC);
    chk(pre_cnt == 8 && pre_ones == 0, "R4", "pre-image clocks", pre_cnt * 100 + pre_ones, 800);
    chk(img_bits == 8 * n, "R5", "image bits", img_bits, 8 * n);
    chk(gap_max == 2 * HALF, "R5", "max clock spacing", gap_max, 2 * HALF);
    for (int k = 0; k < n; k++)
      chk(cap[k] == img[k], "R5 R12", "image byte", int'(cap[k]), int'(img[k]));
    chk(post_cnt == 8 * (NTR + NWK), "R6 R8", "trailing and wake clocks",
        post_cnt, 8 * (NTR + NWK));
    chk(post_ones == 0, "R6", "trailing MOSI ones", post_ones, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rst_n_o == 1'b1 && cfg_cs_n_o == 1'b1, "R11", "reset-state select/reset",
        int'({cfg_rst_n_o, cfg_cs_n_o}), 3);
    chk(cfg_sck_o == 1'b0 && cfg_mosi_o == 1'b0, "R11", "reset-state sck/mosi",
        int'({cfg_sck_o, cfg_mosi_o}), 0);
    chk(busy_o == 1'b0 && ok_o == 1'b0 && err_o == 2'd0 && bs_ready_o == 1'b0, "R11",
        "reset-state status", int'({busy_o, ok_o, err_o, bs_ready_o}), 0);

    // sweep image length on the success path
    for (int n = 1; n <= 5; n++) begin
      run(n, 0, -1, 1'b0, n);
      check_good(n);
    end

    // start while busy is ignored
    run(3, 0, -1, 1'b1, 9);
    chk(rst_falls == 1, "R11", "reset pulses with repeated start", rst_falls, 1);
    check_good(3);

    // done stuck high at the first checkpoint
    run(3, 1, -1, 1'b0, 2);
    chk(err_o == 2'd3, "R3", "status error code", int'(err_o), 3);
    chk(first_rise_cyc < 0, "R3", "no clocks issued", first_rise_cyc, -1);
    chk(ok_o == 1'b0, "R3", "ok stays low", int'(ok_o), 0);

    // done never rises after the trailer
    run(2, 2, -1, 1'b0, 3);
    chk(err_o == 2'd3, "R7", "status error code", int'(err_o), 3);
    chk(post_cnt == 8 * NTR, "R7", "clocks after image", post_cnt, 8 * NTR);
    chk(ok_o == 1'b0, "R7", "ok stays low", int'(ok_o), 0);

    // done rises mid image
    run(4, 3, -1, 1'b0, 4);
    chk(err_o == 2'd2, "R9", "pin error code", int'(err_o), 2);
    chk(post_cnt == 0, "R9", "no trailing clocks", post_cnt, 0);

    // stream underflow on the third byte
    run(4, 0, 2, 1'b0, 5);
    chk(err_o == 2'd1, "R10", "transfer error code", int'(err_o), 1);
    chk(img_bits == 16, "R10", "bits before underflow", img_bits, 16);
    chk(post_cnt == 0, "R10", "no trailing clocks", post_cnt, 0);

    // recovery after an error
    run(2, 0, -1, 1'b0, 6);
    check_good(2);

    finish_all();
  end

endmodule